// File: doc/BRIEF.md
# Burst-Mode Manchester Decoder

This block recovers data and a bit clock from a bi-phase-level serial line. The data sits in the direction of the transition at the middle of each bit cell. A sample clock that runs at a fixed multiple (`OVS`, default 16) of the nominal baud rate drives it. The block has no phase-locked loop and needs no preamble. It accepts the first edge of a burst as a mid-bit transition, so the first bit is out before its own cell has ended. This suits links that stay silent between short bursts.

The line passes through a synchronizer. Each transition then goes through a spacing gate. A transition counts as a mid-bit edge only if at least three quarters of a nominal bit period has passed since the last accepted one. Transitions at bit boundaries are therefore dropped, and the window holds for any rate within ±15% of nominal. The decoded bit leaves the block inverted on `data_n_o`.

The recovered clock `rec_clk_o` is the synchronized line, delayed. Where a bit differs from the one before it, the clock is held low for half a nominal bit period, starting at the mid-bit edge. The recovery logic never makes a falling clock edge of its own while a burst is in progress, so the falling edges keep the timing of the far end. After two quiet bit periods the block drops back to its acquire state and holds the clock low. The block has no data stream interface and therefore no valid/ready handshake and no back-pressure. Both outputs are plain registered levels that change at fixed delays from the line.

Top module: `mdec_top`

## Requirements
- R1: A high-to-low mid-bit transition decodes as bit 1 and a low-to-high one as bit 0. `data_n_o` carries the inverse, so 0 means a decoded 1.
- R2: `data_n_o` changes only in response to an accepted line transition, 3 sample cycles after `rx_i` changes.
- R3: In the acquire state, the first transition is taken as a mid-bit edge. The first bit of a burst is valid on `data_n_o` within one bit period of the burst's start.
- R4: While locked, a transition that arrives fewer than 3·OVS/4 sample cycles after the last accepted edge is ignored. It changes neither `data_n_o` nor the clock shaping.
- R5: Bursts whose baud rate is anywhere from 15% below to 15% above nominal decode without error.
- R6: While locked and outside a hold-low window, `rec_clk_o` equals `rx_i` delayed by 4 sample cycles.
- R7: An accepted edge whose bit differs from the previous decoded bit forces the clock low for OVS/2 sample cycles, starting with that edge's slot.
- R8: While locked, every falling edge of `rec_clk_o` comes from a low line level 4 cycles earlier.
- R9: `data_n_o` is stable in the sample cycle before and the sample cycle after each rising edge of `rec_clk_o`.
- R10: After 2·OVS sample cycles with no accepted edge, the block returns to acquire and `rec_clk_o` stays low.
- R11: During reset, `rec_clk_o` is 0 and `data_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, OVS times the nominal baud rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous encoded line |
| rec_clk_o | output | 1 | Recovered bit clock |
| data_n_o | output | 1 | Decoded data, inverted |

## Verification
The bench drives bursts at nominal rate and at both ±15% extremes. A spacing window set too narrow would let boundary transitions through at the slow rate and flip bits. A window set too wide would swallow real mid-bit edges at the fast rate. Alternating patterns exercise the hold-low window: an off-by-one in its length or start moves a clock rising edge by one sample, and the per-cycle reference catches it. Runs of equal bits check that the clock simply follows the line. The quiet gaps between bursts, each starting on a different line level, check that the block goes back to acquire, takes the next first edge as a mid-bit edge, and holds the clock low while idle.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // One synchronized line sample plus a flag raised when it differs from the prior sample
  typedef struct packed {
    logic toggle;
    logic level;
  } mdec_edge_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync
  import mdec_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output mdec_edge_t ev_o
);

  // chain[STAGES-1] is the synchronized line, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= rx_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign ev_o.level  = chain[STAGES-1];
  assign ev_o.toggle = chain[STAGES-1] ^ chain[STAGES];

endmodule

// File: rtl/mdec_gate.sv
module mdec_gate
  import mdec_pkg::*;
#(
  parameter int unsigned ACC_MIN = 12,
  parameter int unsigned TOUT    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mdec_edge_t ev_i,
  output logic       acc_o,
  output logic       bit_o,
  output logic       locked_o
);

  localparam int unsigned GW = cnt_width(TOUT);
  localparam logic [GW-1:0] TOUT_V = GW'(TOUT);
  localparam logic [GW-1:0] ACC_V  = GW'(ACC_MIN);

  // Cycles since the last accepted edge, parked at TOUT while acquiring
  logic [GW-1:0] gap_q;

  assign locked_o = (gap_q < TOUT_V);
  assign acc_o    = ev_i.toggle & (~locked_o | (gap_q >= ACC_V));
  // New level low means a falling mid-bit edge, i.e. bit 1
  assign bit_o    = ~ev_i.level;

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= TOUT_V;
    else if (acc_o)          gap_q <= GW'(1);
    else if (gap_q < TOUT_V) gap_q <= gap_q + GW'(1);
  end

endmodule

// File: rtl/mdec_clkgen.sv
module mdec_clkgen
  import mdec_pkg::*;
#(
  parameter int unsigned HOLD_LEN = 8,
  parameter int unsigned LAG      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic en_i,
  input  logic swap_i,
  output logic clk_o
);

  localparam int unsigned HW = cnt_width(HOLD_LEN);

  logic [HW-1:0]  hold_q;
  logic           hold_now;
  logic [LAG-1:0] pipe_q;

  assign hold_now = swap_i | (hold_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              hold_q <= '0;
    else if (swap_i)         hold_q <= HW'(HOLD_LEN - 1);
    else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= line_i & en_i & ~hold_now;
  end

  for (genvar i = 1; i < LAG; i++) begin : g_lag
    always_ff @(posedge clk) begin
      if (!rst_n) pipe_q[i] <= 1'b0;
      else        pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign clk_o = pipe_q[LAG-1];

endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rec_clk_o,
  output logic data_n_o
);

  localparam int unsigned ACC_MIN  = (OVS * 3) / 4;
  localparam int unsigned TOUT     = 2 * OVS;
  localparam int unsigned HOLD_LEN = OVS / 2;
  // Clock leaves one cycle after data so data settles before any clock rise
  localparam int unsigned CLK_LAG  = 2;

  mdec_edge_t ev;
  logic sync_lvl, sync_edge;
  logic acc, dec_bit, locked, prev_bit, swap;

  mdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .rx_i (rx_i),
    .ev_o (ev)
  );

  assign sync_lvl  = ev.level;
  assign sync_edge = ev.toggle;

  mdec_gate #(.ACC_MIN(ACC_MIN), .TOUT(TOUT)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .acc_o   (acc),
    .bit_o   (dec_bit),
    .locked_o(locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   data_n_o <= 1'b1;
    else if (acc) data_n_o <= ~dec_bit;
  end

  // The data register already holds the last bit, inverted
  assign prev_bit = ~data_n_o;
  assign swap     = acc & locked & (dec_bit != prev_bit);

  mdec_clkgen #(.HOLD_LEN(HOLD_LEN), .LAG(CLK_LAG)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(sync_lvl),
    .en_i  (locked | acc),
    .swap_i(swap),
    .clk_o (rec_clk_o)
  );

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int unsigned OVS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rec_clk_o,
  input logic data_n_o,
  input logic sync_lvl,
  input logic sync_edge,
  input logic locked
);

  localparam int unsigned TOUT = 2 * OVS;
  localparam int unsigned QMAX = TOUT + 8;
  localparam int unsigned QW   = $clog2(QMAX + 1);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     quiet_q <= '0;
    else if (sync_edge)             quiet_q <= '0;
    else if (quiet_q < QW'(QMAX))   quiet_q <= quiet_q + QW'(1);
  end

  assert_fall_from_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_clk_o) |-> (!$past(sync_lvl, 2) || !$past(locked, 2)));

  assert_high_needs_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_clk_o |-> $past(sync_lvl, 2));

  assert_data_before_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_clk_o) |-> $stable(data_n_o));

  assert_data_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_clk_o) |=> $stable(data_n_o));

  assert_data_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_n_o) |-> $past(sync_edge));

  assert_idle_clock_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q >= QW'(TOUT + 4)) |-> !rec_clk_o);

endmodule

bind mdec_top mdec_checker #(.OVS(OVS)) u_mdec_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rec_clk_o(rec_clk_o),
  .data_n_o (data_n_o),
  .sync_lvl (sync_lvl),
  .sync_edge(sync_edge),
  .locked   (locked)
);

// File: tb/tb_mdec_top.sv
`timescale 1ns/1ps
module tb_mdec_top;

  localparam int OVS     = 16;
  localparam int ACC_MIN = 12;
  localparam int TOUT    = 32;
  localparam int HOLD    = 8;
  localparam int IDLE    = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic rec_clk, data_n;

  always #5 clk = ~clk;

  mdec_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_i     (rx),
    .rec_clk_o(rec_clk),
    .data_n_o (data_n)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit wave[int];
  bit enh[int];
  int cur = 0;
  int dchk_step[$];
  bit dchk_val[$];
  string dchk_tag[$];

  // reference state
  int  last_acc = -1000;
  bit  have_acc = 0;
  bit  prev_bit = 0;
  int  hold_until = -1000;
  bit  clk_q[$];
  string tag_q[$];
  bit  dat_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic burst(input string bits, input real per, input string tag);
    int len, nst;
    len = bits.len();
    nst = int'($ceil(len * per));
    for (int k = 0; k < nst; k++) begin
      int idx;
      bit b, first;
      idx = int'($floor(k / per));
      if (idx >= len) idx = len - 1;
      b = (bits[idx] == "1");
      first = ((k - idx * per) < per / 2.0);
      wave[cur + k] = first ? b : ~b;
    end
    for (int i = 0; i < len; i++) begin
      int ms;
      ms = int'($ceil(i * per + per / 2.0));
      dchk_step.push_back(cur + ms + 4);
      dchk_val.push_back(~(bits[i] == "1"));
      dchk_tag.push_back(i == 0 ? "R3" : tag);
    end
    cur += nst;
    for (int k = 0; k < IDLE; k++) wave[cur + k] = wave[cur - 1];
    cur += IDLE;
  endtask

  initial begin
    real pf, ps;
    bit act_clk, act_dat, last_clk, last_dat;
    pf = OVS / 1.15;
    ps = OVS / 0.85;
    for (int k = 0; k < 20; k++) wave[k] = 1'b0;
    cur = 20;
    burst("01010100", 16.0, "R1");
    burst("111111", 16.0, "R1");
    burst("0000110100", pf, "R5");
    burst("1011001011", ps, "R5");
    burst("01010100", pf, "R5");
    burst("11110000", ps, "R5");

    for (int i = 0; i < 4; i++) begin clk_q.push_back(1'b0); tag_q.push_back("R11"); end
    for (int i = 0; i < 3; i++) dat_q.push_back(1'b1);
    last_clk = 1'b0;
    last_dat = 1'b1;

    for (int n = 0; n < cur; n++) begin
      bit r, rp, edge_s, locked, acc, chg, frc, en, ca, ec, ed;
      int gap;
      string ctag;
      @(negedge clk);
      act_clk = rec_clk;
      act_dat = data_n;
      if (n == 6) rst_n = 1'b1;
      r = wave[n];
      rx = r;
      rp = (n > 0) ? wave[n-1] : 1'b0;

      // reference step for the line value driven now
      edge_s = (r != rp);
      gap = n - last_acc;
      locked = have_acc && (gap < TOUT);
      acc = edge_s && (!locked || gap >= ACC_MIN);
      chg = 1'b0;
      if (acc) begin
        chg = locked && ((!r) != prev_bit);
        prev_bit = !r;
        last_acc = n;
        have_acc = 1'b1;
        if (chg) hold_until = n + HOLD - 1;
      end
      frc = (n <= hold_until);
      en = locked || acc;
      enh[n] = en;
      ca = r & en & !frc;
      ctag = !en ? "R10" : (frc ? "R7" : "R6");
      clk_q.push_back(ca);
      tag_q.push_back(ctag);
      dat_q.push_back(!prev_bit);

      ec = clk_q.pop_front();
      ctag = tag_q.pop_front();
      ed = dat_q.pop_front();
      check(act_clk == ec, ctag, "rec_clk_o", act_clk, ec);
      check(act_dat == ed, "R1 R2 R4", "data_n_o", act_dat, ed);

      if (n == 3) begin
        check(act_clk == 1'b0, "R11", "rec_clk_o in reset", act_clk, 0);
        check(act_dat == 1'b1, "R11", "data_n_o in reset", act_dat, 1);
      end

      while (dchk_step.size() > 0 && dchk_step[0] == n) begin
        bit v;
        string t;
        v = dchk_val.pop_front();
        t = dchk_tag.pop_front();
        void'(dchk_step.pop_front());
        check(act_dat == v, t, "decoded bit", act_dat, v);
      end

      if (act_clk && !last_clk)
        check(act_dat == last_dat, "R9", "data at clock rise", act_dat, last_dat);
      if (!act_clk && last_clk && n >= 4 && enh[n-4])
        check(wave[n-4] == 1'b0, "R8", "line before clock fall", wave[n-4], 0);

      last_clk = act_clk;
      last_dat = act_dat;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule